// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block holds the instruction address of a small processor and decides its next value every cycle. The counter is 11 bits wide and spans 2048 instruction words. A source multiplexer chooses what the counter loads: the next sequential address, an absolute target from the instruction, the entry on top of the return stack, or its own current value. The counter changes only on a clock edge where the load strobe or the increment control is high.

Subroutine calls use a hardware return stack of eight entries. The stack pointer wraps in a circle. The entry at the current pointer is always shown on an output. A call raises the push control, the write strobe and a jump load in the same cycle. The stack then stores the counter plus one in the slot above and advances the pointer. A return raises the pop control and loads the counter from the stack source. Overflow and underflow wrap without raising any flag. The instruction controller drives all controls. Decoding and pipeline flushing are handled outside this block.

Top module: `prog_counter_unit`

## Requirements
- R1: After reset the counter reads 0, the stack pointer is 0, every stack entry holds 0, and so `stack_top` reads 0.
- R2: With `pc_load` and `pc_inc` both low, the counter keeps its value across the clock edge.
- R3: With `pc_inc` high and `pc_load` low, the counter advances by one. It wraps from 2047 to 0.
- R4: With `pc_load` high and `pc_src` = 2'b01, the counter loads `jump_addr`. `pc_load` takes priority over `pc_inc`.
- R5: With `pc_load` high and `pc_src` = 2'b00, the counter loads its current value plus one.
- R6: With `pc_load` high and `pc_src` = 2'b10, the counter loads the value `stack_top` showed before the edge.
- R7: `stk_push` without `stk_pop` moves the pointer up by one. When `stk_wr` is also high, the new slot receives the counter value plus one, and `stack_top` shows that value after the edge.
- R8: `stk_pop` without `stk_push` moves the pointer down by one, so `stack_top` shows the entry below.
- R9: A ninth push without a pop wraps the pointer and overwrites the oldest entry. No error is reported. Eight pops then return the eight newest addresses, newest first.
- R10: A pop at pointer 0 wraps the pointer to 7 and raises no error.
- R11: With `pc_load` high and `pc_src` = 2'b11, the counter keeps its value.
- R12: `stk_wr` with neither push nor pop writes the counter value plus one into the current entry, and the pointer stays put.
- R13: `stk_push` and `stk_pop` raised together leave the pointer unchanged. A write in that cycle goes to the current entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_load | input | 1 | Load the counter from the selected source |
| pc_inc | input | 1 | Advance the counter by one when no load |
| pc_src | input | 2 | Source: 00 next, 01 jump, 10 stack, 11 hold |
| jump_addr | input | 11 | Absolute target field from the instruction |
| stk_push | input | 1 | Move stack pointer up |
| stk_pop | input | 1 | Move stack pointer down |
| stk_wr | input | 1 | Write counter plus one to the target slot |
| imem_addr | output | 11 | Current counter, instruction-memory address |
| stack_top | output | 11 | Entry at the current stack pointer |

## Verification
The embedded properties assume that every control input is a known value on each clock edge after reset, and that `pc_src` is one of its four codes. The properties check hold, increment, jump load, stack load and the stack write-through against these inputs. The bench changes inputs only on the falling edge and returns every control to zero between operations. Calls and returns are raised as the controller would raise them, with push, write and jump in one cycle and pop with a stack-source load in one cycle. The bench also drives a few deliberate off-pattern combinations, such as a push together with a pop and a write with no pointer move, to reach the wrap and overwrite corners.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [1:0] {
        SRC_SEQ   = 2'b00,
        SRC_JUMP  = 2'b01,
        SRC_STACK = 2'b10,
        SRC_HOLD  = 2'b11
    } pc_src_e;
endpackage

// File: rtl/pcs_next_sel.sv
module pcs_next_sel
    import pcs_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic [1:0]    sel,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] jump,
    input  logic [AW-1:0] top,
    output logic [AW-1:0] nxt
);
    always_comb begin
        unique case (pc_src_e'(sel))
            SRC_SEQ:   nxt = cur + AW'(1);
            SRC_JUMP:  nxt = jump;
            SRC_STACK: nxt = top;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/pcs_counter.sv
module pcs_counter #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          inc,
    input  logic [AW-1:0] nxt,
    output logic [AW-1:0] pc
);
    typedef struct packed {
        logic [AW-1:0] pc;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d.pc = nxt;
        else if (inc)
            st_d.pc = st_q.pc + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc = st_q.pc;

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !inc) |=> $stable(pc));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && inc) |=> pc == AW'($past(pc) + AW'(1)));
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int AW    = 11,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          wr,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] top
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] ent;
        logic [PW-1:0]            sp;
    } stk_t;

    stk_t st_d, st_q;
    logic [PW-1:0] tgt;

    function automatic logic [PW-1:0] ptr_up(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] ptr_dn(input logic [PW-1:0] p);
        return (p == '0) ? LAST : p - PW'(1);
    endfunction

    always_comb begin
        if (push && !pop)      tgt = ptr_up(st_q.sp);
        else if (pop && !push) tgt = ptr_dn(st_q.sp);
        else                   tgt = st_q.sp;
        st_d    = st_q;
        st_d.sp = tgt;
        if (wr)
            st_d.ent[tgt] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top = st_q.ent[st_q.sp];

    // R7
    push_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && wr) |=> top == $past(wdata));

    // R12
    wr_inplace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (push == pop)) |=> top == $past(wdata));

    // R13
    still_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !wr) |=> $stable(top));
endmodule

// File: rtl/prog_counter_unit.sv
module prog_counter_unit
    import pcs_pkg::*;
#(
    parameter int AW    = 11,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pc_load,
    input  logic          pc_inc,
    input  logic [1:0]    pc_src,
    input  logic [AW-1:0] jump_addr,
    input  logic          stk_push,
    input  logic          stk_pop,
    input  logic          stk_wr,
    output logic [AW-1:0] imem_addr,
    output logic [AW-1:0] stack_top
);
    logic [AW-1:0] pc_cur, pc_nxt, ret_addr, top_w;

    assign ret_addr = pc_cur + AW'(1);

    pcs_next_sel #(.AW(AW)) u_sel (
        .sel (pc_src),
        .cur (pc_cur),
        .jump(jump_addr),
        .top (top_w),
        .nxt (pc_nxt)
    );

    pcs_counter #(.AW(AW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (pc_load),
        .inc  (pc_inc),
        .nxt  (pc_nxt),
        .pc   (pc_cur)
    );

    pcs_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
        .clk  (clk),
        .rst_n(rst_n),
        .push (stk_push),
        .pop  (stk_pop),
        .wr   (stk_wr),
        .wdata(ret_addr),
        .top  (top_w)
    );

    assign imem_addr = pc_cur;
    assign stack_top = top_w;

    // R4
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_src == SRC_JUMP) |=> imem_addr == $past(jump_addr));

    // R6
    ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_src == SRC_STACK) |=> imem_addr == $past(stack_top));

    // R11
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_src == SRC_HOLD) |=> $stable(imem_addr));
endmodule

// File: tb/tb_prog_counter_unit.sv
module tb_prog_counter_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_load = 0, pc_inc = 0, stk_push = 0, stk_pop = 0, stk_wr = 0;
    logic [1:0]  pc_src = 0;
    logic [10:0] jump_addr = 0;
    logic [10:0] imem_addr, stack_top;
    int errs = 0, checks = 0;

    always #10 clk = ~clk;

    prog_counter_unit dut (
        .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_inc(pc_inc),
        .pc_src(pc_src), .jump_addr(jump_addr), .stk_push(stk_push),
        .stk_pop(stk_pop), .stk_wr(stk_wr), .imem_addr(imem_addr),
        .stack_top(stack_top)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at a falling edge, wait through one rising edge, sample at next falling edge
    task automatic cyc(input logic ld, input logic [1:0] src, input logic inc,
                       input int tgt, input logic pu, input logic po, input logic w);
        pc_load = ld; pc_src = src; pc_inc = inc; jump_addr = 11'(tgt);
        stk_push = pu; stk_pop = po; stk_wr = w;
        @(negedge clk);
        pc_load = 0; pc_inc = 0; stk_push = 0; stk_pop = 0; stk_wr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pc", imem_addr, 0);
        chk("R1 stack_top", stack_top, 0);
    endtask

    task automatic t_sequencing();
        cyc(0, 2'b00, 0, 0, 0, 0, 0);
        chk("R2 idle at 0", imem_addr, 0);
        cyc(1, 2'b01, 0, 100, 0, 0, 0);
        chk("R4 jump", imem_addr, 100);
        cyc(0, 2'b01, 0, 555, 0, 0, 0);
        chk("R2 idle ignores target", imem_addr, 100);
        cyc(0, 2'b00, 1, 0, 0, 0, 0);
        chk("R3 inc", imem_addr, 101);
        cyc(1, 2'b00, 0, 0, 0, 0, 0);
        chk("R5 seq load", imem_addr, 102);
        cyc(1, 2'b11, 1, 7, 0, 0, 0);
        chk("R11 hold source", imem_addr, 102);
        cyc(1, 2'b01, 1, 2047, 0, 0, 0);
        chk("R4 load over inc", imem_addr, 2047);
        cyc(0, 2'b00, 1, 0, 0, 0, 0);
        chk("R3 wrap", imem_addr, 0);
    endtask

    task automatic t_call_return();
        do_reset();
        cyc(1, 2'b01, 0, 10, 0, 0, 0);
        cyc(1, 2'b01, 0, 200, 1, 0, 1);
        chk("R7 call pc", imem_addr, 200);
        chk("R7 call top", stack_top, 11);
        cyc(1, 2'b01, 0, 300, 1, 0, 1);
        chk("R7 nested top", stack_top, 201);
        cyc(1, 2'b10, 0, 0, 0, 1, 0);
        chk("R6 return pc", imem_addr, 201);
        chk("R8 pop top", stack_top, 11);
        cyc(1, 2'b10, 0, 0, 0, 1, 0);
        chk("R6 second return", imem_addr, 11);
        chk("R8 back to slot 0", stack_top, 0);
    endtask

    task automatic t_underflow_and_inplace();
        do_reset();
        cyc(0, 2'b00, 0, 0, 0, 1, 0);
        chk("R10 underflow top", stack_top, 0);
        chk("R10 pc untouched", imem_addr, 0);
        cyc(1, 2'b01, 0, 50, 0, 0, 0);
        cyc(0, 2'b00, 0, 0, 0, 0, 1);
        chk("R12 in place write", stack_top, 51);
        cyc(1, 2'b01, 0, 60, 0, 0, 0);
        cyc(0, 2'b00, 0, 0, 1, 1, 1);
        chk("R13 push+pop write", stack_top, 61);
        cyc(0, 2'b00, 0, 0, 1, 0, 0);
        chk("R10 pointer was 7, now slot 0", stack_top, 0);
        cyc(0, 2'b00, 0, 0, 0, 1, 0);
        chk("R8 pop to slot 7", stack_top, 61);
    endtask

    task automatic t_overflow();
        do_reset();
        cyc(1, 2'b01, 0, 16, 0, 0, 0);
        for (int i = 1; i <= 9; i++)
            cyc(1, 2'b01, 0, (i + 1) * 16, 1, 0, 1);
        chk("R9 top after nine", stack_top, 9 * 16 + 1);
        for (int k = 1; k <= 8; k++) begin
            cyc(1, 2'b10, 0, 0, 0, 1, 0);
            chk($sformatf("R9 pop %0d", k), imem_addr, (10 - k) * 16 + 1);
        end
        chk("R9 oldest overwritten", stack_top, 9 * 16 + 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_sequencing();
                t_call_return();
                t_underflow_and_inplace();
                t_overflow();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; errs++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule